// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block sits beside a processor's execution pipeline and decides, each time an instruction retires, whether an external interrupt should be taken before the next instruction begins. Two request sources are watched. The first is a level-sensitive maskable request, gated by an internal interrupt-enable flag that the core clears and sets with one-cycle commands. The second is a non-maskable request. Its rising edges are captured and held until they are serviced, and it ignores the enable flag.

Once an interrupt is accepted, the block runs a short entry sequence. A maskable interrupt first gets one acknowledge cycle, during which the vector number is read from an external data input. The block then asks for three stack pushes in a fixed order, one cycle each: the flags word, then the code segment, then the instruction pointer. The non-maskable interrupt skips the acknowledge cycle and uses a fixed vector. The enable flag is cleared as part of acceptance, so the handler starts with maskable interrupts blocked.

The boundary that directly follows an instruction which loaded the stack-segment register accepts nothing. This shadow lets the paired stack-pointer load finish before any push can use the half-updated stack.

Top module: `intr_entry_seq`

## Requirements
- R1: After reset, the enable flag reads 0, busy_o is 0, vec_o is 00h, and no acknowledge or push strobe is active.
- R2: A pulse on ien_set_i makes ien_o 1 on the next cycle, and a pulse on ien_clr_i makes it 0. When both pulse in the same cycle, the clear wins.
- R3: At an idle boundary with ien_o=1, mreq_i=1 and no pending non-maskable event, a maskable interrupt is accepted. ack_o is high for exactly the one cycle after the boundary. The value on vec_data_i in that cycle appears on vec_o on the next cycle and stays unchanged until the sequence ends.
- R4: While ien_o=0, a maskable request is never accepted, and busy_o stays 0 after the boundary.
- R5: A rising edge on nmi_i is latched as a pending event. The next eligible boundary accepts it whatever the value of ien_o. No ack_o pulse is given, and vec_o holds 02h during the pushes.
- R6: When a non-maskable event is pending and a maskable request is also eligible at the same boundary, the non-maskable one is taken. The maskable one can be accepted at a later boundary.
- R7: The entry pushes are push_flags_o, push_cs_o and push_ip_o, in that order, on consecutive cycles. Only one strobe of ack_o and the three pushes is high in any cycle. The first push comes in the cycle after ack_o (maskable) or in the cycle after the boundary (non-maskable). busy_o falls in the cycle after push_ip_o.
- R8: Acceptance of either kind clears the enable flag from the cycle after the boundary, even if ien_set_i pulses in the boundary cycle.
- R9: A boundary with ss_load_i=1 accepts neither kind of interrupt. Any pending request is taken at the following boundary.
- R10: boundary_i is ignored while busy_o=1. A non-maskable edge that arrives during an entry stays pending and is serviced at the next boundary after the entry ends.
- R11: A non-maskable input held high produces only one acceptance. A further acceptance needs a new rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boundary_i | input | 1 | One-cycle strobe: an instruction has just retired |
| ss_load_i | input | 1 | Qualifies boundary_i: the retiring instruction wrote the stack segment |
| ien_set_i | input | 1 | Set the interrupt-enable flag |
| ien_clr_i | input | 1 | Clear the interrupt-enable flag |
| mreq_i | input | 1 | Maskable interrupt request, level |
| nmi_i | input | 1 | Non-maskable interrupt request, rising-edge sensitive |
| vec_data_i | input | VEC_W | Vector number from the interrupt controller, read during ack_o |
| ien_o | output | 1 | Current interrupt-enable flag |
| busy_o | output | 1 | Entry sequence in progress |
| ack_o | output | 1 | One-cycle acknowledge for a maskable interrupt |
| vec_o | output | VEC_W | Vector of the interrupt being entered |
| push_flags_o | output | 1 | Request: push the flags word |
| push_cs_o | output | 1 | Request: push the code segment |
| push_ip_o | output | 1 | Request: push the instruction pointer |

## Verification
The assertions check the following on every cycle:
- the strobe ordering and one-hot rule of the entry sequence;
- the enable flag being cleared on acceptance, and the clear command winning over set;
- the stability of the vector during the pushes;
- that nothing is accepted under the stack-segment shadow or while masked;
- that a pending non-maskable event goes straight to the flags push.

Only the bench scenarios can show the following. The vector actually captured from the data input is the right one. A non-maskable edge that arrives during an entry, or behind a shadow, is kept and serviced later. A held non-maskable level produces only one entry. The maskable request that lost to a non-maskable one is still taken afterwards.

// File: rtl/intr_seq_pkg.sv
// Package: shared types for the interrupt entry sequencer.
// Assumes: one acceptance decision per boundary, evaluated only when the sequencer is idle.
package intr_seq_pkg;

    // Entry sequencer states
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ACK    = 3'd1,
        ST_PFLAGS = 3'd2,
        ST_PCS    = 3'd3,
        ST_PIP    = 3'd4
    } seq_state_t;

    // Outcome of the acceptance decision at a boundary
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_MASK = 2'd1,
        ACC_NMI  = 2'd2
    } accept_kind_t;

endpackage

// File: rtl/nmi_edge_latch.sv
// Module: nmi_edge_latch
// Detects rising edges of the non-maskable request and holds one pending event
// until the acceptance logic takes it.
// Assumes: nmi_i is already synchronous to clk.
// A new edge in the same cycle as a take keeps the event pending.
module nmi_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_i,
    input  logic take_i,
    output logic pend_o
);

    logic nmi_q;
    logic rise;

    // Edge detection against the previous sample
    assign rise = nmi_i & ~nmi_q;

    // Register the previous sample of the request line
    always_ff @(posedge clk) begin
        if (!rst_n) nmi_q <= 1'b0;
        else        nmi_q <= nmi_i;
    end

    // Pending flag: set on an edge, cleared when taken; a set wins over a take
    always_ff @(posedge clk) begin
        if (!rst_n)      pend_o <= 1'b0;
        else if (rise)   pend_o <= 1'b1;
        else if (take_i) pend_o <= 1'b0;
    end

    // R5: a non-maskable acceptance is only possible with an event pending
    p_take_needs_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> pend_o);

    // R11: a held level cannot re-arm the latch once taken
    p_no_rearm_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && nmi_i && nmi_q) |=> !pend_o);

endmodule

// File: rtl/ien_flag.sv
// Module: ien_flag
// Holds the interrupt-enable flag. Priority from high to low: acceptance,
// clear command, set command.
// Assumes: the command pulses are one cycle wide.
module ien_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic accept_i,
    output logic ien_o
);

    // Flag update with acceptance and clear taking priority over set
    always_ff @(posedge clk) begin
        if (!rst_n)                  ien_o <= 1'b0;
        else if (accept_i || clr_i)  ien_o <= 1'b0;
        else if (set_i)              ien_o <= 1'b1;
    end

    // R8: acceptance leaves the flag cleared on the next cycle
    p_accept_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        accept_i |=> !ien_o);

    // R2: the clear command wins over a simultaneous set
    p_clr_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !ien_o);

    // R2: a lone set command raises the flag
    p_set_raises_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !clr_i && !accept_i) |=> ien_o);

endmodule

// File: rtl/accept_arbiter.sv
// Module: accept_arbiter
// Combinational decision at an instruction boundary. The non-maskable event
// beats the maskable request. Nothing is taken under the stack-segment
// shadow or while an entry is running.
// Assumes: boundary_i is a single-cycle strobe.
module accept_arbiter
    import intr_seq_pkg::*;
(
    input  logic         boundary_i,
    input  logic         ss_load_i,
    input  logic         idle_i,
    input  logic         ien_i,
    input  logic         mreq_i,
    input  logic         nmi_pend_i,
    output accept_kind_t kind_o
);

    logic eligible;

    // A boundary counts only when idle and not shadowed
    assign eligible = boundary_i & idle_i & ~ss_load_i;

    // Priority selection between the two request sources
    always_comb begin
        kind_o = ACC_NONE;
        if (eligible) begin
            if (nmi_pend_i)          kind_o = ACC_NMI;
            else if (ien_i && mreq_i) kind_o = ACC_MASK;
        end
    end

endmodule

// File: rtl/entry_sequencer.sv
// Module: entry_sequencer
// Runs the entry: an optional acknowledge cycle that captures the vector,
// then three one-cycle push requests (flags, code segment, instruction pointer).
// Assumes: kind_i is non-NONE only while the sequencer is idle.
module entry_sequencer
    import intr_seq_pkg::*;
#(
    parameter int               VEC_W   = 8,
    parameter logic [VEC_W-1:0] NMI_VEC = 'h02
) (
    input  logic             clk,
    input  logic             rst_n,
    input  accept_kind_t     kind_i,
    input  logic [VEC_W-1:0] vec_data_i,
    output logic             ack_o,
    output logic             push_flags_o,
    output logic             push_cs_o,
    output logic             push_ip_o,
    output logic             busy_o,
    output logic [VEC_W-1:0] vec_o
);

    seq_state_t state;

    // State walk and vector capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            vec_o <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (kind_i == ACC_NMI) begin
                        state <= ST_PFLAGS;
                        vec_o <= NMI_VEC;
                    end else if (kind_i == ACC_MASK) begin
                        state <= ST_ACK;
                    end
                end
                ST_ACK: begin
                    vec_o <= vec_data_i;
                    state <= ST_PFLAGS;
                end
                ST_PFLAGS: state <= ST_PCS;
                ST_PCS:    state <= ST_PIP;
                ST_PIP:    state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    // Strobe decode from the current state
    always_comb begin
        ack_o        = (state == ST_ACK);
        push_flags_o = (state == ST_PFLAGS);
        push_cs_o    = (state == ST_PCS);
        push_ip_o    = (state == ST_PIP);
        busy_o       = (state != ST_IDLE);
    end

    // R7: acknowledge is followed by the flags push
    p_ack_then_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> push_flags_o);
    // R7: flags push then code segment push
    p_flags_then_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push_flags_o |=> push_cs_o);
    // R7: code segment push then instruction pointer push
    p_cs_then_ip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push_cs_o |=> push_ip_o);
    // R7: the sequence ends right after the last push
    p_ip_then_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push_ip_o |=> !busy_o);
    // R7: at most one strobe per cycle
    p_one_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ack_o, push_flags_o, push_cs_o, push_ip_o}));
    // R3: the vector holds still across the later pushes
    p_vec_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_cs_o || push_ip_o) |-> $stable(vec_o));

endmodule

// File: rtl/intr_entry_seq.sv
// Module: intr_entry_seq (top)
// Interrupt acceptance at instruction boundaries plus the entry sequence.
// Ties together the non-maskable edge latch, the enable flag, the acceptance
// arbiter and the entry sequencer.
// Assumes: all inputs are synchronous to clk; boundary_i is a one-cycle strobe.
module intr_entry_seq
    import intr_seq_pkg::*;
#(
    parameter int               VEC_W   = 8,
    parameter logic [VEC_W-1:0] NMI_VEC = 'h02
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boundary_i,
    input  logic             ss_load_i,
    input  logic             ien_set_i,
    input  logic             ien_clr_i,
    input  logic             mreq_i,
    input  logic             nmi_i,
    input  logic [VEC_W-1:0] vec_data_i,
    output logic             ien_o,
    output logic             busy_o,
    output logic             ack_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             push_flags_o,
    output logic             push_cs_o,
    output logic             push_ip_o
);

    accept_kind_t kind;
    logic         nmi_pend;
    logic         take_nmi;
    logic         accept;

    // Acceptance summaries used by the flag and the latch
    assign take_nmi = (kind == ACC_NMI);
    assign accept   = (kind != ACC_NONE);

    nmi_edge_latch u_nmi (
        .clk    (clk),
        .rst_n  (rst_n),
        .nmi_i  (nmi_i),
        .take_i (take_nmi),
        .pend_o (nmi_pend)
    );

    ien_flag u_ien (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (ien_set_i),
        .clr_i    (ien_clr_i),
        .accept_i (accept),
        .ien_o    (ien_o)
    );

    accept_arbiter u_arb (
        .boundary_i (boundary_i),
        .ss_load_i  (ss_load_i),
        .idle_i     (!busy_o),
        .ien_i      (ien_o),
        .mreq_i     (mreq_i),
        .nmi_pend_i (nmi_pend),
        .kind_o     (kind)
    );

    entry_sequencer #(
        .VEC_W   (VEC_W),
        .NMI_VEC (NMI_VEC)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .kind_i       (kind),
        .vec_data_i   (vec_data_i),
        .ack_o        (ack_o),
        .push_flags_o (push_flags_o),
        .push_cs_o    (push_cs_o),
        .push_ip_o    (push_ip_o),
        .busy_o       (busy_o),
        .vec_o        (vec_o)
    );

    // R9: a shadowed boundary starts nothing
    p_shadow_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary_i && ss_load_i && !busy_o) |=> !busy_o);
    // R4: masked with nothing non-maskable pending, no entry starts
    p_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary_i && !busy_o && !ien_o && !nmi_pend) |=> !busy_o);
    // R6: a pending non-maskable event goes straight to the flags push
    p_nmi_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary_i && !ss_load_i && !busy_o && nmi_pend) |=> (push_flags_o && vec_o == NMI_VEC));
    // R10: an entry is not restarted by a boundary while it runs
    p_busy_ignores_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !push_ip_o) |=> busy_o);

endmodule

// File: tb/intr_entry_seq_tb.sv
// Scoreboard bench: the driver tasks queue the expected strobe events,
// and the monitor pops and compares them as the design produces them.
module intr_entry_seq_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       boundary_i = 1'b0, ss_load_i = 1'b0;
    logic       ien_set_i = 1'b0, ien_clr_i = 1'b0;
    logic       mreq_i = 1'b0, nmi_i = 1'b0;
    logic [7:0] vec_data_i = 8'h00;
    logic       ien_o, busy_o, ack_o, push_flags_o, push_cs_o, push_ip_o;
    logic [7:0] vec_o;

    int n_checks = 0;
    int n_fail   = 0;
    int q_code[$];
    logic [7:0] q_vec[$];
    int last_code = 0;

    always #10 clk = ~clk; // 50 MHz

    intr_entry_seq u_dut (
        .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .ss_load_i(ss_load_i),
        .ien_set_i(ien_set_i), .ien_clr_i(ien_clr_i), .mreq_i(mreq_i), .nmi_i(nmi_i),
        .vec_data_i(vec_data_i), .ien_o(ien_o), .busy_o(busy_o), .ack_o(ack_o),
        .vec_o(vec_o), .push_flags_o(push_flags_o), .push_cs_o(push_cs_o),
        .push_ip_o(push_ip_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Driver side: queue the strobes of a maskable or non-maskable entry
    task automatic expect_mask(input logic [7:0] v);
        q_code.push_back(1); q_vec.push_back(8'h00);
        q_code.push_back(2); q_vec.push_back(v);
        q_code.push_back(3); q_vec.push_back(v);
        q_code.push_back(4); q_vec.push_back(v);
    endtask

    task automatic expect_nmi();
        for (int k = 2; k <= 4; k++) begin
            q_code.push_back(k); q_vec.push_back(8'h02);
        end
    endtask

    task automatic boundary(input bit ss);
        boundary_i = 1'b1; ss_load_i = ss;
        @(negedge clk);
        boundary_i = 1'b0; ss_load_i = 1'b0;
    endtask

    task automatic pulse_set(); ien_set_i = 1'b1; @(negedge clk); ien_set_i = 1'b0; endtask
    task automatic pulse_clr(); ien_clr_i = 1'b1; @(negedge clk); ien_clr_i = 1'b0; endtask
    task automatic pulse_nmi(); nmi_i = 1'b1; @(negedge clk); nmi_i = 1'b0; @(negedge clk); endtask

    task automatic wait_idle();
        while (busy_o) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: compares each strobe cycle against the scoreboard, sampled away from the edge
    always @(negedge clk) begin
        int code;
        int cnt;
        if (rst_n) begin
            cnt  = int'(ack_o) + int'(push_flags_o) + int'(push_cs_o) + int'(push_ip_o);
            code = ack_o ? 1 : push_flags_o ? 2 : push_cs_o ? 3 : push_ip_o ? 4 : 0;
            if (cnt > 1) chk(1'b0, "R7 one strobe", cnt, 1);
            if (last_code >= 1 && last_code <= 3)
                chk(code == last_code + 1, "R7 consecutive pushes", code, last_code + 1);
            if (code != 0) begin
                if (q_code.size() == 0) begin
                    chk(1'b0, "R4/R9/R10/R11 unexpected strobe", code, 0);
                end else begin
                    int ec;
                    logic [7:0] ev;
                    ec = q_code.pop_front();
                    ev = q_vec.pop_front();
                    chk(code == ec, "R6/R7 strobe order", code, ec);
                    if (code > 1) chk(vec_o == ev, "R3/R5 vector", vec_o, ev);
                end
            end
            last_code = code;
        end
    end

    // Watchdog: counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(ien_o == 0, "R1 ien", ien_o, 0);
        chk(busy_o == 0, "R1 busy", busy_o, 0);
        chk(vec_o == 0, "R1 vec", vec_o, 0);
        chk({ack_o, push_flags_o, push_cs_o, push_ip_o} == 0, "R1 strobes",
            {ack_o, push_flags_o, push_cs_o, push_ip_o}, 0);

        // R2 flag commands
        pulse_set();
        chk(ien_o == 1, "R2 set", ien_o, 1);
        pulse_clr();
        chk(ien_o == 0, "R2 clear", ien_o, 0);
        pulse_set();
        ien_set_i = 1'b1; ien_clr_i = 1'b1;
        @(negedge clk);
        ien_set_i = 1'b0; ien_clr_i = 1'b0;
        chk(ien_o == 0, "R2 clear wins", ien_o, 0);

        // R4 masked request ignored
        mreq_i = 1'b1;
        boundary(1'b0);
        chk(busy_o == 0, "R4 masked", busy_o, 0);
        @(negedge clk);

        // R3 and R8 maskable acceptance
        pulse_set();
        vec_data_i = 8'h4B;
        expect_mask(8'h4B);
        boundary(1'b0);
        chk(busy_o == 1, "R3 accepted", busy_o, 1);
        chk(ien_o == 0, "R8 cleared on accept", ien_o, 0);
        wait_idle();
        chk(vec_o == 8'h4B, "R3 vector held", vec_o, 8'h4B);

        // R8 acceptance overrides a simultaneous set
        pulse_set();
        vec_data_i = 8'h21;
        expect_mask(8'h21);
        ien_set_i = 1'b1;
        boundary(1'b0);
        ien_set_i = 1'b0;
        chk(ien_o == 0, "R8 accept beats set", ien_o, 0);
        wait_idle();
        mreq_i = 1'b0;

        // R5 non-maskable with flag clear
        pulse_nmi();
        repeat (3) @(negedge clk);
        expect_nmi();
        boundary(1'b0);
        chk(busy_o == 1 && ack_o == 0, "R5 nmi no ack", {busy_o, ack_o}, 2'b10);
        wait_idle();

        // R6 precedence, then the maskable request later
        pulse_set();
        mreq_i = 1'b1;
        vec_data_i = 8'h77;
        pulse_nmi();
        expect_nmi();
        boundary(1'b0);
        wait_idle();
        pulse_set();
        expect_mask(8'h77);
        boundary(1'b0);
        chk(busy_o == 1, "R6 maskable later", busy_o, 1);
        wait_idle();

        // R9 shadow blocks maskable, next boundary takes it
        pulse_set();
        vec_data_i = 8'h35;
        boundary(1'b1);
        chk(busy_o == 0, "R9 shadow maskable", busy_o, 0);
        chk(ien_o == 1, "R9 flag kept", ien_o, 1);
        expect_mask(8'h35);
        boundary(1'b0);
        wait_idle();
        mreq_i = 1'b0;

        // R9 shadow blocks non-maskable too
        pulse_nmi();
        boundary(1'b1);
        chk(busy_o == 0, "R9 shadow nmi", busy_o, 0);
        expect_nmi();
        boundary(1'b0);
        wait_idle();

        // R10 edge and boundary during an entry
        pulse_set();
        mreq_i = 1'b1;
        vec_data_i = 8'h5C;
        expect_mask(8'h5C);
        boundary(1'b0);
        mreq_i = 1'b0;
        nmi_i = 1'b1; boundary_i = 1'b1;
        @(negedge clk);
        nmi_i = 1'b0; boundary_i = 1'b0;
        wait_idle();
        chk(vec_o == 8'h5C, "R10 entry not disturbed", vec_o, 8'h5C);
        expect_nmi();
        boundary(1'b0);
        chk(busy_o == 1, "R10 pending kept", busy_o, 1);
        wait_idle();

        // R11 held level gives one acceptance
        nmi_i = 1'b1;
        repeat (2) @(negedge clk);
        expect_nmi();
        boundary(1'b0);
        wait_idle();
        boundary(1'b0);
        chk(busy_o == 0, "R11 no second entry", busy_o, 0);
        nmi_i = 1'b0;
        repeat (4) @(negedge clk);

        chk(q_code.size() == 0, "R7 all expected strobes seen", q_code.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule